// File: doc/BRIEF.md
# USB Attach and High-Speed Detector

This block watches the digitised state of a USB 2.0 data pair and reports three things. It reports whether a device or test fixture is present. It reports whether the link has reached high-speed signalling, which is the condition for turning on channel compensation. It also gives a two-bit speed code. Analog front-end circuits give it a decoded line code (SE0, J, K, or idle/other), pulses for pull-up detection, disconnect, squelch and test-packet recognition, and a level for test-fixture detection. A local divider turns the system clock into microsecond ticks, and a saturating duration counter uses these ticks to time each line state.

High speed is entered on one of two paths. On the normal path the link must see a USB bus reset (SE0 held long enough), then exactly one chirp J followed by one chirp K, each within the chirp-duration window, and finally a squelch indication. Any deviation from this sequence drops the link back to full-speed operation until the next bus reset. On the test path a fixture is recognised from the unconnected state and a test packet is then observed. Low-speed and full-speed links show as connected but never enable compensation. Reset, and a configuration-hold input, force the block idle.

Top module: `usbhs_attach_det`

## Requirements
- R1: While `rst_n` is low, `conn_flag` and `hs_en` are 0 and `speed_mode` is 2'b00, and detection pulses seen during reset have no lasting effect.
- R2: From the unconnected state, a `pullup_det` pulse sets `conn_flag` to 1 and `speed_mode` to 2'b01 (full/low speed) at the next clock edge.
- R3: A `disc_det` pulse in any state clears `conn_flag` and `hs_en` and sets `speed_mode` to 2'b00 at the next clock edge.
- R4: While attached at full speed, a bus reset is recognised only when the line code is SE0 (2'b00) for at least RESET_US microseconds. A shorter SE0 does not open the handshake.
- R5: After a bus reset, a chirp J (code 2'b01) followed directly by a chirp K (code 2'b10), then SE0 or idle (2'b11), followed by a `sq_det` pulse, sets `hs_en` to 1 and `speed_mode` to 2'b10. `hs_en` stays 0 until that squelch pulse.
- R6: Each chirp counts as valid only if it lasts between CHIRP_MIN_US and CHIRP_MAX_US whole microseconds inclusive, where a chirp of L clocks lasts floor(L / CLKS_PER_US) microseconds. A chirp outside the window aborts the handshake. The link stays at full speed until a later bus reset and valid handshake.
- R7: A broken chirp order aborts the handshake, and a later squelch pulse leaves `hs_en` at 0. This covers K before J, J after K, and any further J or K while waiting for squelch.
- R8: From the unconnected state, a `fixture_det` pulse sets `conn_flag` (speed 2'b01). A following `tpkt_det` pulse sets `hs_en` and `speed_mode` 2'b10.
- R9: While `cfg_hold` is 1 the block is held unconnected with both flags 0, and pull-up and fixture indications are ignored.
- R10: A full-speed link never sets `hs_en` from `sq_det` or `tpkt_det` without a completed handshake. `speed_mode` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLKS_PER_US cycles per microsecond |
| rst_n | input | 1 | Active-low asynchronous reset / shutdown |
| cfg_hold | input | 1 | Configuration hold; forces the idle state |
| line_state | input | 2 | Decoded line: 00 SE0, 01 J, 10 K, 11 idle/other |
| pullup_det | input | 1 | Pull-up detected on a data line |
| disc_det | input | 1 | Disconnect detected |
| sq_det | input | 1 | Squelch detected |
| fixture_det | input | 1 | High-speed test fixture detected |
| tpkt_det | input | 1 | Test-packet pattern recognised |
| conn_flag | output | 1 | Connection detected |
| hs_en | output | 1 | High-speed active; enables compensation |
| speed_mode | output | 2 | 00 none, 01 full/low, 10 high |

## Verification
The bench probes the chirp window on both edges at clock precision. It uses a J one clock short of the minimum, a J exactly at the minimum, a K exactly at the maximum and a K one clock past it. An off-by-one in the tick divider or counter would accept a short chirp or reject a legal one. The bench breaks the chirp order in three ways and sends a too-short SE0, because a design that only counted chirps, or did not require a real bus reset, would enter high speed on a malformed exchange. It also sends squelch and test-packet pulses to a plain full-speed link, and uses reset, disconnect and configuration hold at different points. A design that leaked an intermediate state would leave `hs_en` or `conn_flag` set.

// File: rtl/usbhs_pkg.sv
`timescale 1ns/1ps
package usbhs_pkg;

   // decoded line code presented by the front end
   typedef enum logic [1:0] {
      LN_SE0  = 2'b00,
      LN_J    = 2'b01,
      LN_K    = 2'b10,
      LN_IDLE = 2'b11
   } line_e;

   typedef enum logic [1:0] {
      SPD_NONE = 2'b00,
      SPD_FULL = 2'b01,
      SPD_HIGH = 2'b10
   } speed_e;

   typedef enum logic [2:0] {
      ST_UNCONN  = 3'd0,
      ST_FIXTURE = 3'd1,
      ST_ATT_FS  = 3'd2,
      ST_RST_SEEN= 3'd3,
      ST_CHIRP_J = 3'd4,
      ST_CHIRP_K = 3'd5,
      ST_WAIT_SQ = 3'd6,
      ST_HS      = 3'd7
   } link_st_e;

   function automatic int dur_width(input int longest_us);
      return $clog2(longest_us + 2);
   endfunction

endpackage

// File: rtl/usbhs_line_track.sv
`timescale 1ns/1ps
module usbhs_line_track
   import usbhs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_in,
   output logic       line_chg
);

   logic [1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= LN_IDLE;
      else        line_q <= line_in;
   end

   assign line_chg = (line_in != line_q);

endmodule

// File: rtl/usbhs_dur_timer.sv
`timescale 1ns/1ps
module usbhs_dur_timer #(
   parameter int CLKS_PER_US = 60,
   parameter int DUR_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [DUR_W-1:0] dur_us
);

   localparam logic [DUR_W-1:0] DUR_SAT = '1;

   if (CLKS_PER_US < 1) begin : g_bad_div
      $error("usbhs_dur_timer: CLKS_PER_US must be at least 1");
   end
   if (DUR_W < 2) begin : g_bad_width
      $error("usbhs_dur_timer: DUR_W must be at least 2");
   end

   if (CLKS_PER_US == 1) begin : g_direct
      // every clock is a microsecond; the clearing clock counts as the first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                dur_us <= '0;
         else if (clr)              dur_us <= DUR_W'(1);
         else if (dur_us != DUR_SAT) dur_us <= dur_us + 1'b1;
      end
   end else begin : g_divided
      localparam int DIV_W = $clog2(CLKS_PER_US);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_US - 1);
      logic [DIV_W-1:0] div_q;
      logic             tick;

      assign tick = (div_q == DIV_LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q  <= '0;
            dur_us <= '0;
         end else if (clr) begin
            div_q  <= DIV_W'(1);
            dur_us <= '0;
         end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick && dur_us != DUR_SAT) dur_us <= dur_us + 1'b1;
         end
      end
   end

endmodule

// File: rtl/usbhs_link_fsm.sv
`timescale 1ns/1ps
module usbhs_link_fsm
   import usbhs_pkg::*;
#(
   parameter int DUR_W        = 8,
   parameter int RESET_US     = 3,
   parameter int CHIRP_MIN_US = 18,
   parameter int CHIRP_MAX_US = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_hold,
   input  logic             disc_det,
   input  logic             pullup_det,
   input  logic             fixture_det,
   input  logic             tpkt_det,
   input  logic             sq_det,
   input  logic [1:0]       line_in,
   input  logic             line_chg,
   input  logic [DUR_W-1:0] dur_us,
   output logic             conn_flag,
   output logic             hs_en,
   output logic [1:0]       speed_mode
);

   localparam logic [DUR_W-1:0] RST_LIM = DUR_W'(RESET_US);
   localparam logic [DUR_W-1:0] WIN_LO  = DUR_W'(CHIRP_MIN_US);
   localparam logic [DUR_W-1:0] WIN_HI  = DUR_W'(CHIRP_MAX_US);

   link_st_e st_q, st_d;
   speed_e   spd_q;
   logic     in_win, overrun, quiet_line;

   assign in_win     = (dur_us >= WIN_LO) && (dur_us <= WIN_HI);
   assign overrun    = (dur_us > WIN_HI);
   assign quiet_line = (line_in == LN_SE0) || (line_in == LN_IDLE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_UNCONN: begin
            if (fixture_det)     st_d = ST_FIXTURE;
            else if (pullup_det) st_d = ST_ATT_FS;
         end
         ST_FIXTURE: begin
            if (tpkt_det) st_d = ST_HS;
         end
         ST_ATT_FS: begin
            if (line_in == LN_SE0 && !line_chg && dur_us >= RST_LIM)
               st_d = ST_RST_SEEN;
         end
         ST_RST_SEEN: begin
            if (line_chg) begin
               if (line_in == LN_J)      st_d = ST_CHIRP_J;
               else if (line_in == LN_K) st_d = ST_ATT_FS;
            end
         end
         ST_CHIRP_J: begin
            if (line_chg)
               st_d = (line_in == LN_K && in_win) ? ST_CHIRP_K : ST_ATT_FS;
            else if (overrun)
               st_d = ST_ATT_FS;
         end
         ST_CHIRP_K: begin
            if (line_chg)
               st_d = (quiet_line && in_win) ? ST_WAIT_SQ : ST_ATT_FS;
            else if (overrun)
               st_d = ST_ATT_FS;
         end
         ST_WAIT_SQ: begin
            if (!quiet_line) st_d = ST_ATT_FS;
            else if (sq_det) st_d = ST_HS;
         end
         ST_HS:   st_d = ST_HS;
         default: st_d = ST_UNCONN;
      endcase
      if (disc_det) st_d = ST_UNCONN;
      if (cfg_hold) st_d = ST_UNCONN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_UNCONN;
         conn_flag <= 1'b0;
         hs_en     <= 1'b0;
         spd_q     <= SPD_NONE;
      end else begin
         st_q      <= st_d;
         conn_flag <= (st_d != ST_UNCONN);
         hs_en     <= (st_d == ST_HS);
         spd_q     <= (st_d == ST_UNCONN) ? SPD_NONE :
                      (st_d == ST_HS)     ? SPD_HIGH : SPD_FULL;
      end
   end

   assign speed_mode = spd_q;

endmodule

// File: rtl/usbhs_attach_det.sv
`timescale 1ns/1ps
module usbhs_attach_det
   import usbhs_pkg::*;
#(
   parameter int CLKS_PER_US  = 60,
   parameter int RESET_US     = 3,
   parameter int CHIRP_MIN_US = 18,
   parameter int CHIRP_MAX_US = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_hold,
   input  logic [1:0] line_state,
   input  logic       pullup_det,
   input  logic       disc_det,
   input  logic       sq_det,
   input  logic       fixture_det,
   input  logic       tpkt_det,
   output logic       conn_flag,
   output logic       hs_en,
   output logic [1:0] speed_mode
);

   localparam int LONGEST_US = (CHIRP_MAX_US > RESET_US) ? CHIRP_MAX_US : RESET_US;
   localparam int DUR_W      = dur_width(LONGEST_US);

   if (CHIRP_MIN_US < 1 || CHIRP_MIN_US > CHIRP_MAX_US) begin : g_bad_window
      $error("usbhs_attach_det: chirp window must satisfy 1 <= MIN <= MAX");
   end
   if (RESET_US < 1) begin : g_bad_reset
      $error("usbhs_attach_det: RESET_US must be at least 1");
   end

   logic             line_chg;
   logic [DUR_W-1:0] dur_us;

   usbhs_line_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (line_state),
      .line_chg (line_chg)
   );

   usbhs_dur_timer #(
      .CLKS_PER_US (CLKS_PER_US),
      .DUR_W       (DUR_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (line_chg),
      .dur_us (dur_us)
   );

   usbhs_link_fsm #(
      .DUR_W        (DUR_W),
      .RESET_US     (RESET_US),
      .CHIRP_MIN_US (CHIRP_MIN_US),
      .CHIRP_MAX_US (CHIRP_MAX_US)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_hold    (cfg_hold),
      .disc_det    (disc_det),
      .pullup_det  (pullup_det),
      .fixture_det (fixture_det),
      .tpkt_det    (tpkt_det),
      .sq_det      (sq_det),
      .line_in     (line_state),
      .line_chg    (line_chg),
      .dur_us      (dur_us),
      .conn_flag   (conn_flag),
      .hs_en       (hs_en),
      .speed_mode  (speed_mode)
   );

endmodule

// File: rtl/usbhs_attach_chk.sv
`timescale 1ns/1ps
module usbhs_attach_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_hold,
   input logic       pullup_det,
   input logic       disc_det,
   input logic       sq_det,
   input logic       fixture_det,
   input logic       tpkt_det,
   input logic       conn_flag,
   input logic       hs_en,
   input logic [1:0] speed_mode
);

   AST_CONN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conn_flag) |-> $past(pullup_det || fixture_det)); // R2

   AST_DISC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      disc_det |=> (!conn_flag && !hs_en && speed_mode == 2'b00)); // R3

   AST_HS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(sq_det || tpkt_det)); // R5

   AST_HS_HAS_CONN: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en |-> conn_flag); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hold |=> (!conn_flag && !hs_en)); // R9

   AST_SPEED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      speed_mode != 2'b11); // R10

   AST_FULL_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
      (speed_mode == 2'b01) |-> !hs_en); // R10

endmodule

bind usbhs_attach_det usbhs_attach_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_hold    (cfg_hold),
   .pullup_det  (pullup_det),
   .disc_det    (disc_det),
   .sq_det      (sq_det),
   .fixture_det (fixture_det),
   .tpkt_det    (tpkt_det),
   .conn_flag   (conn_flag),
   .hs_en       (hs_en),
   .speed_mode  (speed_mode)
);

// File: tb/tb_usbhs_attach_det.sv
`timescale 1ns/1ps
module tb_usbhs_attach_det;

   localparam int P = 4;
   localparam logic [1:0] L_SE0 = 2'b00, L_J = 2'b01, L_K = 2'b10, L_IDLE = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_hold = 1'b0;
   logic [1:0] line_state = L_IDLE;
   logic       pullup_det = 1'b0, disc_det = 1'b0, sq_det = 1'b0;
   logic       fixture_det = 1'b0, tpkt_det = 1'b0;
   logic       conn_flag, hs_en;
   logic [1:0] speed_mode;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   usbhs_attach_det #(
      .CLKS_PER_US (P),
      .RESET_US    (3),
      .CHIRP_MIN_US(18),
      .CHIRP_MAX_US(128)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .line_state(line_state),
      .pullup_det(pullup_det), .disc_det(disc_det), .sq_det(sq_det),
      .fixture_det(fixture_det), .tpkt_det(tpkt_det),
      .conn_flag(conn_flag), .hs_en(hs_en), .speed_mode(speed_mode)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_out(input string req, input int c, input int h, input int s);
      check(req, "conn_flag", conn_flag, c);
      check(req, "hs_en", hs_en, h);
      check(req, "speed_mode", speed_mode, s);
   endtask

   task automatic hold_line(input logic [1:0] code, input int cycles);
      line_state = code;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic pulse_pullup();  pullup_det = 1;  @(negedge clk); pullup_det = 0;  endtask
   task automatic pulse_disc();    disc_det = 1;    @(negedge clk); disc_det = 0;    endtask
   task automatic pulse_sq();      sq_det = 1;      @(negedge clk); sq_det = 0;      endtask
   task automatic pulse_fixture(); fixture_det = 1; @(negedge clk); fixture_det = 0; endtask
   task automatic pulse_tpkt();    tpkt_det = 1;    @(negedge clk); tpkt_det = 0;    endtask

   // bus reset, J, K, back to idle
   task automatic exchange(input int se0_cyc, input int j_cyc, input int k_cyc);
      hold_line(L_SE0, se0_cyc);
      hold_line(L_J, j_cyc);
      hold_line(L_K, k_cyc);
      hold_line(L_IDLE, 2);
   endtask

   task automatic t_reset_state();
      repeat (3) @(negedge clk);
      check_out("R1", 0, 0, 0);
      pullup_det = 1; fixture_det = 1;
      @(negedge clk);
      pullup_det = 0; fixture_det = 0;
      check_out("R1", 0, 0, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      check_out("R1", 0, 0, 0);
   endtask

   task automatic t_full_speed_only();
      pulse_pullup();
      check_out("R2", 1, 0, 1);
      pulse_sq();
      check_out("R10", 1, 0, 1);
      pulse_tpkt();
      check_out("R10", 1, 0, 1);
      pulse_disc();
      check_out("R3", 0, 0, 0);
   endtask

   task automatic t_good_handshake();
      pulse_pullup();
      exchange(20, 72, 515);   // J at minimum, K at maximum
      check_out("R5", 1, 0, 1);
      pulse_sq();
      check_out("R5", 1, 1, 2);
      pulse_disc();
      check_out("R3", 0, 0, 0);
   endtask

   task automatic t_short_reset();
      pulse_pullup();
      exchange(8, 80, 80);     // SE0 only 2 us
      pulse_sq();
      check_out("R4", 1, 0, 1);
      pulse_disc();
   endtask

   task automatic t_window();
      pulse_pullup();
      exchange(20, 71, 80);    // J one clock short
      pulse_sq();
      check_out("R6", 1, 0, 1);
      exchange(20, 80, 516);   // K one clock long
      pulse_sq();
      check_out("R6", 1, 0, 1);
      exchange(20, 80, 80);    // retry after abort
      pulse_sq();
      check_out("R6", 1, 1, 2);
      pulse_disc();
   endtask

   task automatic t_order();
      pulse_pullup();
      hold_line(L_SE0, 20);
      hold_line(L_K, 80);      // K first
      hold_line(L_J, 80);
      hold_line(L_K, 80);
      hold_line(L_IDLE, 2);
      pulse_sq();
      check_out("R7", 1, 0, 1);
      hold_line(L_SE0, 20);
      hold_line(L_J, 80);
      hold_line(L_K, 80);
      hold_line(L_J, 80);      // second J directly after K
      hold_line(L_IDLE, 2);
      pulse_sq();
      check_out("R7", 1, 0, 1);
      exchange(20, 80, 80);
      hold_line(L_J, 80);      // chirp while waiting for squelch
      hold_line(L_IDLE, 2);
      pulse_sq();
      check_out("R7", 1, 0, 1);
      hold_line(L_SE0, 20);
      hold_line(L_J, 10);
      pulse_disc();            // disconnect mid-chirp
      check_out("R3", 0, 0, 0);
      hold_line(L_IDLE, 2);
   endtask

   task automatic t_fixture();
      pulse_fixture();
      check_out("R8", 1, 0, 1);
      pulse_tpkt();
      check_out("R8", 1, 1, 2);
      pulse_disc();
      check_out("R3", 0, 0, 0);
   endtask

   task automatic t_hold();
      cfg_hold = 1;
      pulse_pullup();
      check_out("R9", 0, 0, 0);
      pulse_fixture();
      check_out("R9", 0, 0, 0);
      cfg_hold = 0;
      @(negedge clk);
      check_out("R9", 0, 0, 0);
      pulse_fixture();
      pulse_tpkt();
      check_out("R9", 1, 1, 2);
      cfg_hold = 1;
      @(negedge clk);
      check_out("R9", 0, 0, 0);
      cfg_hold = 0;
      @(negedge clk);
   endtask

   task automatic t_shutdown();
      pulse_pullup();
      exchange(20, 80, 80);
      pulse_sq();
      check_out("R5", 1, 1, 2);
      rst_n = 0;
      @(negedge clk);
      check_out("R1", 0, 0, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      check_out("R1", 0, 0, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset_state();
      t_full_speed_only();
      t_good_handshake();
      t_short_reset();
      t_window();
      t_order();
      t_fixture();
      t_hold();
      t_shutdown();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule